// File: doc/BRIEF.md
# Ethernet DMA Control and Status Register File

This block is the software-visible register file of a descriptor-based Ethernet DMA. A host reaches it through a simple word-addressed read/write port; byte addresses are decoded with the two low bits dropped. It holds the DMA status word, the interrupt enable mask, the bus mode word and the operation control word. For each direction it also holds a descriptor list base pointer and a current-descriptor pointer. It drives one level-sensitive interrupt line toward the system.

The transmit and receive engines are outside this block. They raise status events through single-cycle set inputs. In return they receive a one-cycle start pulse whenever software writes the transmit poll register, plus the two enable bits and the current descriptor pointers. Software acknowledges events by writing ones to the status word. Programming a list base also rewinds that direction's current pointer to the same address.

The port is plain control: a write takes effect at the clock edge where `wr_en` is sampled high. A read presents `rdata` with `rd_valid` one cycle after `rd_en`. There is no back-pressure, so the port accepts one access of each kind every cycle.

Top module: `dma_csr_regs`

Register map (byte address, word index): 0x00 identity (0), 0x04 bus mode (1), 0x08 operation control (2), 0x0C interrupt mask (3), 0x10 status (4), 0x14 transmit poll (5), 0x18 receive list base (6), 0x1C transmit list base (7), 0x20 receive current pointer (8), 0x24 transmit current pointer (9).

## Requirements
- R1: After reset, every storage register reads 0, `irq`, `rx_enable`, `tx_enable` and `tx_poll_pulse` are low, and both descriptor pointer outputs are 0.
- R2: A write to the status word (index 4) clears each status bit whose written bit is 1 and leaves the bits written as 0 unchanged.
- R3: Each engine set input sets its status bits at the next edge: `tx_done_set` sets bits 0 and 16, `tx_unavail_set` sets bits 2 and 15, `rx_done_set` sets bits 6 and 16, and `rx_unavail_set` sets bits 7 and 15.
- R4: When a set input and a software clear hit the same status bit in one cycle, the bit ends set.
- R5: `irq` is high exactly when the status word ANDed with the interrupt mask (index 3) is nonzero, and it follows the registers updated at the preceding edge.
- R6: Writing a list base (index 6 receive, index 7 transmit) loads the same value into that direction's current pointer. A current pointer (index 8 or 9) may also be written directly without changing its base. The current pointers drive `rx_desc_ptr` and `tx_desc_ptr`.
- R7: Bit 0 of the bus mode word (index 1) always reads 0; the other bits read back as written.
- R8: The identity word (index 0) always reads 0x1012, and writes to it are ignored.
- R9: A write to the transmit poll register (index 5) raises `tx_poll_pulse` for exactly one cycle after the write edge and stores nothing; the register reads 0.
- R10: Operation control bit 1 drives `rx_enable` and bit 13 drives `tx_enable`.
- R11: Indices above 9, and any address whose two low bits are not 0, read as 0, and writes to them change no register.
- R12: `rd_valid` rises exactly one cycle after each `rd_en` and carries the data selected by the address of that read.
- R13: Status bits other than 0, 2, 6, 7, 15 and 16 never become 1, and no write can set a status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rdata | output | DATA_W | Read data |
| tx_done_set | input | 1 | Transmit frame finished event |
| tx_unavail_set | input | 1 | Transmit descriptor not owned event |
| rx_done_set | input | 1 | Receive frame finished event |
| rx_unavail_set | input | 1 | Receive descriptor not owned event |
| irq | output | 1 | Level interrupt |
| tx_poll_pulse | output | 1 | One-cycle transmit start request |
| rx_enable | output | 1 | Reception enabled |
| tx_enable | output | 1 | Transmission enabled |
| rx_desc_ptr | output | DATA_W | Current receive descriptor pointer |
| tx_desc_ptr | output | DATA_W | Current transmit descriptor pointer |

## Verification
The bench targets a clear of every status bit arriving in the same cycle as a receive-done event. A design that lets the clear win would lose that event and report status 0 instead of 0x10040. It checks that a base write rewinds the current pointer while a direct pointer write leaves the base alone; a shared register would show the new pointer value in the base. It also checks that the interrupt follows the mask, so a design that ignores the mask would assert `irq` with the mask at 0. Finally, misaligned and out-of-range writes must not alias onto real registers, and the soft-reset bit, the identity word and the poll register must resist writes.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  // word indices of the register map
  localparam int IDX_IDENT   = 0;
  localparam int IDX_BUSMODE = 1;
  localparam int IDX_OPCTRL  = 2;
  localparam int IDX_INTMASK = 3;
  localparam int IDX_STATUS  = 4;
  localparam int IDX_TXPOLL  = 5;
  localparam int IDX_RXBASE  = 6;
  localparam int IDX_TXBASE  = 7;
  localparam int IDX_RXCUR   = 8;
  localparam int IDX_TXCUR   = 9;
  localparam int NUM_REGS    = 10;

  localparam logic [31:0] IDENT_VALUE = 32'h0000_1012;

  // status bit positions
  localparam int ST_TX_DONE    = 0;
  localparam int ST_TX_UNAVAIL = 2;
  localparam int ST_RX_DONE    = 6;
  localparam int ST_RX_UNAVAIL = 7;
  localparam int ST_ABN_SUM    = 15;
  localparam int ST_NRM_SUM    = 16;

  // control bit positions
  localparam int OPC_RX_EN  = 1;
  localparam int OPC_TX_EN  = 13;
  localparam int BM_SOFTRST = 0;

  // descriptor channels
  localparam int CH_RX  = 0;
  localparam int CH_TX  = 1;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic tx_done;
    logic tx_unavail;
    logic rx_done;
    logic rx_unavail;
  } dma_evt_t;
endpackage

// File: rtl/dma_csr_status.sv
module dma_csr_status
  import dma_csr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] clr_mask,
  input  dma_evt_t          evt,
  input  logic [DATA_W-1:0] int_mask,
  output logic [DATA_W-1:0] status,
  output logic              irq
);
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] keep_vec;

  always_comb begin
    set_vec = '0;
    if (evt.tx_done) begin
      set_vec[ST_TX_DONE] = 1'b1;
      set_vec[ST_NRM_SUM] = 1'b1;
    end
    if (evt.rx_done) begin
      set_vec[ST_RX_DONE] = 1'b1;
      set_vec[ST_NRM_SUM] = 1'b1;
    end
    if (evt.tx_unavail) begin
      set_vec[ST_TX_UNAVAIL] = 1'b1;
      set_vec[ST_ABN_SUM]    = 1'b1;
    end
    if (evt.rx_unavail) begin
      set_vec[ST_RX_UNAVAIL] = 1'b1;
      set_vec[ST_ABN_SUM]    = 1'b1;
    end
  end

  // write-one-to-clear, engine events take priority
  assign keep_vec = clr_en ? ~clr_mask : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & keep_vec) | set_vec;
  end

  assign status = status_q;
  assign irq    = |(status_q & int_mask);
endmodule

// File: rtl/dma_csr_ptr.sv
module dma_csr_ptr #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr,
  input  logic              cur_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] base,
  output logic [DATA_W-1:0] cur
);
  logic [DATA_W-1:0] base_q;
  logic [DATA_W-1:0] cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (base_wr) begin
      base_q <= wdata;
      cur_q  <= wdata;
    end else if (cur_wr) begin
      cur_q  <= wdata;
    end
  end

  assign base = base_q;
  assign cur  = cur_q;
endmodule

// File: rtl/dma_csr_regs.sv
module dma_csr_regs
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rdata,
  input  logic              tx_done_set,
  input  logic              tx_unavail_set,
  input  logic              rx_done_set,
  input  logic              rx_unavail_set,
  output logic              irq,
  output logic              tx_poll_pulse,
  output logic              rx_enable,
  output logic              tx_enable,
  output logic [DATA_W-1:0] rx_desc_ptr,
  output logic [DATA_W-1:0] tx_desc_ptr
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [DATA_W-1:0] SOFTRST_MASK = DATA_W'(1) << BM_SOFTRST;

  logic [IDX_W-1:0]    word_idx;
  logic                aligned;
  logic [NUM_REGS-1:0] wr_hit;
  logic [DATA_W-1:0]   busmode_q;
  logic [DATA_W-1:0]   opctrl_q;
  logic [DATA_W-1:0]   inten_q;
  logic [DATA_W-1:0]   status_w;
  logic                poll_q;
  logic                rd_valid_q;
  logic [DATA_W-1:0]   rdata_q;
  logic [DATA_W-1:0]   rd_mux;
  logic [DATA_W-1:0]   base_w [NUM_CH];
  logic [DATA_W-1:0]   cur_w  [NUM_CH];
  dma_evt_t            evt;

  assign word_idx = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);

  // one write strobe per implemented word
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign wr_hit[i] = wr_en && aligned && (word_idx == IDX_W'(i));
  end

  assign evt = '{tx_done:    tx_done_set,
                 tx_unavail: tx_unavail_set,
                 rx_done:    rx_done_set,
                 rx_unavail: rx_unavail_set};

  dma_csr_status #(.DATA_W(DATA_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_en   (wr_hit[IDX_STATUS]),
    .clr_mask (wdata),
    .evt      (evt),
    .int_mask (inten_q),
    .status   (status_w),
    .irq      (irq)
  );

  // base/current pointer pair per direction
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int BASE_IDX = (c == CH_RX) ? IDX_RXBASE : IDX_TXBASE;
    localparam int CUR_IDX  = (c == CH_RX) ? IDX_RXCUR  : IDX_TXCUR;
    dma_csr_ptr #(.DATA_W(DATA_W)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .base_wr (wr_hit[BASE_IDX]),
      .cur_wr  (wr_hit[CUR_IDX]),
      .wdata   (wdata),
      .base    (base_w[c]),
      .cur     (cur_w[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busmode_q <= '0;
      opctrl_q  <= '0;
      inten_q   <= '0;
      poll_q    <= 1'b0;
    end else begin
      if (wr_hit[IDX_BUSMODE]) busmode_q <= wdata & ~SOFTRST_MASK;
      if (wr_hit[IDX_OPCTRL])  opctrl_q  <= wdata;
      if (wr_hit[IDX_INTMASK]) inten_q   <= wdata;
      poll_q <= wr_hit[IDX_TXPOLL];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      case (word_idx)
        IDX_W'(IDX_IDENT):   rd_mux = DATA_W'(IDENT_VALUE);
        IDX_W'(IDX_BUSMODE): rd_mux = busmode_q;
        IDX_W'(IDX_OPCTRL):  rd_mux = opctrl_q;
        IDX_W'(IDX_INTMASK): rd_mux = inten_q;
        IDX_W'(IDX_STATUS):  rd_mux = status_w;
        IDX_W'(IDX_RXBASE):  rd_mux = base_w[CH_RX];
        IDX_W'(IDX_TXBASE):  rd_mux = base_w[CH_TX];
        IDX_W'(IDX_RXCUR):   rd_mux = cur_w[CH_RX];
        IDX_W'(IDX_TXCUR):   rd_mux = cur_w[CH_TX];
        default:             rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rdata_q    <= '0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign rd_valid      = rd_valid_q;
  assign rdata         = rdata_q;
  assign tx_poll_pulse = poll_q;
  assign rx_enable     = opctrl_q[OPC_RX_EN];
  assign tx_enable     = opctrl_q[OPC_TX_EN];
  assign rx_desc_ptr   = cur_w[CH_RX];
  assign tx_desc_ptr   = cur_w[CH_TX];
endmodule

// File: rtl/dma_csr_checker.sv
module dma_csr_checker
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rdata,
  input logic              tx_done_set,
  input logic              rx_done_set,
  input logic              irq,
  input logic              tx_poll_pulse,
  input logic [DATA_W-1:0] rx_desc_ptr,
  input logic [DATA_W-1:0] status_w,
  input logic [DATA_W-1:0] inten_q
);
  localparam int IDX_W = ADDR_W - 2;

  logic at_status, at_rxbase, at_poll, at_ident, at_busmode;
  assign at_status  = addr[1:0] == 2'b00 && addr[ADDR_W-1:2] == IDX_W'(IDX_STATUS);
  assign at_rxbase  = addr[1:0] == 2'b00 && addr[ADDR_W-1:2] == IDX_W'(IDX_RXBASE);
  assign at_poll    = addr[1:0] == 2'b00 && addr[ADDR_W-1:2] == IDX_W'(IDX_TXPOLL);
  assign at_ident   = addr[1:0] == 2'b00 && addr[ADDR_W-1:2] == IDX_W'(IDX_IDENT);
  assign at_busmode = addr[1:0] == 2'b00 && addr[ADDR_W-1:2] == IDX_W'(IDX_BUSMODE);

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && at_status && wdata[ST_RX_DONE] && !rx_done_set) |=> !status_w[ST_RX_DONE]); // R2

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_set |=> (status_w[ST_TX_DONE] && status_w[ST_NRM_SUM])); // R3

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_set && wr_en && at_status) |=> status_w[ST_RX_DONE]); // R4

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (inten_q == '0) |-> !irq); // R5

  AST_BASE_RELOADS_CUR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && at_rxbase) |=> (rx_desc_ptr == $past(wdata))); // R6

  AST_SOFTRST_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && at_busmode) |=> !rdata[BM_SOFTRST]); // R7

  AST_IDENT_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && at_ident) |=> (rdata == DATA_W'(IDENT_VALUE))); // R8

  AST_POLL_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_poll_pulse |-> $past(wr_en && at_poll)); // R9

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en)); // R12

  AST_STATUS_BITS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (status_w & ~((DATA_W'(1) << ST_TX_DONE) | (DATA_W'(1) << ST_TX_UNAVAIL) |
                  (DATA_W'(1) << ST_RX_DONE) | (DATA_W'(1) << ST_RX_UNAVAIL) |
                  (DATA_W'(1) << ST_ABN_SUM) | (DATA_W'(1) << ST_NRM_SUM))) == '0); // R13
endmodule

bind dma_csr_regs dma_csr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/dma_csr_regs_tb_top.sv
module dma_csr_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        rd_valid;
  logic [31:0] rdata;
  logic        tx_done_set = 1'b0, tx_unavail_set = 1'b0;
  logic        rx_done_set = 1'b0, rx_unavail_set = 1'b0;
  logic        irq, tx_poll_pulse, rx_enable, tx_enable;
  logic [31:0] rx_desc_ptr, tx_desc_ptr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_csr_regs dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_valid(rd_valid), .rdata(rdata),
    .tx_done_set(tx_done_set), .tx_unavail_set(tx_unavail_set),
    .rx_done_set(rx_done_set), .rx_unavail_set(rx_unavail_set),
    .irq(irq), .tx_poll_pulse(tx_poll_pulse), .rx_enable(rx_enable),
    .tx_enable(tx_enable), .rx_desc_ptr(rx_desc_ptr), .tx_desc_ptr(tx_desc_ptr)
  );

  function automatic logic [7:0] ba(int idx);
    return 8'(idx * 4);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per returned read (R12)
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R12 unexpected rd_valid act=1 exp=0");
      end else begin
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  // all tasks start and end at a falling edge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic evt(bit td, bit tu, bit rdn, bit ru);
    tx_done_set = td; tx_unavail_set = tu; rx_done_set = rdn; rx_unavail_set = ru;
    @(negedge clk);
    tx_done_set = 0; tx_unavail_set = 0; rx_done_set = 0; rx_unavail_set = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 enables", {30'b0, rx_enable, tx_enable}, 0);
    chk("R1 poll", {31'b0, tx_poll_pulse}, 0);
    chk("R1 rx ptr", rx_desc_ptr, 0);
    chk("R1 tx ptr", tx_desc_ptr, 0);
    rd(ba(4), 0, "R1 status");
    rd(ba(3), 0, "R1 mask");
    rd(ba(2), 0, "R1 opctrl");
    chk("R12 idle rd_valid", {31'b0, rd_valid}, 1);
    @(negedge clk);
    chk("R12 rd_valid drops", {31'b0, rd_valid}, 0);

    // R8 identity word
    rd(ba(0), 32'h1012, "R8 ident");
    wr(ba(0), 32'hFFFF_FFFF);
    rd(ba(0), 32'h1012, "R8 ident after write");

    // R7 soft reset bit
    wr(ba(1), 32'hFFFF_FFFF);
    rd(ba(1), 32'hFFFF_FFFE, "R7 busmode");
    wr(ba(1), 32'h0000_0025);
    rd(ba(1), 32'h0000_0024, "R7 busmode pattern");

    // R10 enables
    wr(ba(2), 32'h0000_0002);
    chk("R10 rx only", {30'b0, rx_enable, tx_enable}, 2);
    wr(ba(2), 32'h0000_2000);
    chk("R10 tx only", {30'b0, rx_enable, tx_enable}, 1);

    // R6 base/current pointers
    wr(ba(6), 32'h1000_0040);
    chk("R6 rx ptr out", rx_desc_ptr, 32'h1000_0040);
    rd(ba(8), 32'h1000_0040, "R6 rx cur reload");
    wr(ba(8), 32'h1000_0080);
    rd(ba(6), 32'h1000_0040, "R6 rx base kept");
    rd(ba(8), 32'h1000_0080, "R6 rx cur direct");
    wr(ba(7), 32'h2000_0100);
    chk("R6 tx ptr out", tx_desc_ptr, 32'h2000_0100);
    chk("R6 rx ptr untouched", rx_desc_ptr, 32'h1000_0080);

    // R9 poll pulse
    wr(ba(5), 32'h1);
    chk("R9 pulse high", {31'b0, tx_poll_pulse}, 1);
    @(negedge clk);
    chk("R9 pulse one cycle", {31'b0, tx_poll_pulse}, 0);
    rd(ba(5), 0, "R9 poll reads zero");

    // R3 / R5 events and interrupt
    evt(1, 0, 0, 0);
    rd(ba(4), 32'h0001_0001, "R3 tx done");
    chk("R5 masked off", {31'b0, irq}, 0);
    wr(ba(3), 32'h0000_0001);
    chk("R5 mask on", {31'b0, irq}, 1);
    wr(ba(4), 32'h0000_0001);
    chk("R5 irq after clear", {31'b0, irq}, 0);
    rd(ba(4), 32'h0001_0000, "R2 partial clear");
    wr(ba(4), 32'h0001_0000);
    rd(ba(4), 0, "R2 full clear");

    evt(0, 0, 0, 1);
    rd(ba(4), 32'h0000_8080, "R3 rx unavail");
    evt(0, 1, 0, 0);
    rd(ba(4), 32'h0000_8084, "R3 tx unavail");
    evt(0, 0, 1, 0);
    rd(ba(4), 32'h0001_80C4, "R3 rx done");
    chk("R5 bit0 clear irq low", {31'b0, irq}, 0);
    wr(ba(3), 32'h0000_0080);
    chk("R5 bit7 mask", {31'b0, irq}, 1);

    // R4 set wins over clear in the same cycle
    rx_done_set = 1'b1;
    wr(ba(4), 32'hFFFF_FFFF);
    rx_done_set = 1'b0;
    rd(ba(4), 32'h0001_0040, "R4 set beats clear");
    chk("R5 bit7 cleared", {31'b0, irq}, 0);

    // R13 writes never set status
    wr(ba(4), 32'hFFFF_FFFF);
    rd(ba(4), 0, "R13 cleared");
    wr(ba(4), 32'h0000_0000);
    rd(ba(4), 0, "R13 zero write");

    // R11 unimplemented and misaligned
    wr(ba(12), 32'hDEAD_BEEF);
    rd(ba(12), 0, "R11 out of range");
    rd(8'hFC, 0, "R11 top word");
    wr(ba(3) + 8'd1, 32'h0);
    rd(ba(3), 32'h0000_0080, "R11 misaligned write ignored");
    rd(ba(0) + 8'd2, 0, "R11 misaligned read");

    repeat (3) @(negedge clk);
    chk("R12 queue drained", 32'(exp_q.size()), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R12 watchdog act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule